// File: doc/BRIEF.md
# Timestamp-Ordered Sparse Pixel Readout

This block collects hits from a small matrix of binary pixels and sends them out as sparse words, sorted by time. A timestamp counter is broadcast to every pixel. It advances once every `TICK_DIV` clocks and wraps at its width. When the hit input of an idle pixel fires, that pixel stores the current timestamp and keeps it until the pixel is read out or discarded.

Readout works on one requested timestamp at a time. Each pixel compares its stored stamp with the requested value. Each column ORs its pixels' match bits into a fast-OR flag. Only the flagged columns are visited, lowest index first, at one clock per column however many rows have hits. Each visit produces one word that carries the timestamp, the column index and a row bitmap. The words leave through a valid/ready port.

There are two modes. In data-push mode every timestamp is drained, in order, once the counter has moved past it. In triggered mode a trigger pulse requests the timestamp a programmable latency behind the current one. The pixel latches act as the latency buffer. Hits that age past the latency without being requested are dropped.

Top module: `tsr_readout`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `ts_now` is 0.
- R2: `ts_now` advances by one every `TICK_DIV` clocks (8 by default) and wraps modulo 2^`TS_W` (15 to 0 for the default width of 4). The first step comes `TICK_DIV` clocks after reset release.
- R3: A hit pulse on `hit_in[c*N_ROWS + r]` stores the current `ts_now` in pixel (column c, row r). The word that reads this pixel carries that value in `out_ts`.
- R4: A pixel that holds an unread hit ignores further hit pulses until it is cleared.
- R5: For one requested timestamp, only the columns that hold matching hits produce a word, in ascending column order. The words come on consecutive accepted cycles. `out_col` is the column index and bit r of `out_rows` is row r. A word never has an all-zero bitmap.
- R6: In data-push mode (`mode_trig`=0), the hits of timestamp T are presented starting in the first cycle in which `ts_now` shows T+1.
- R7: While `out_valid` is 1 and `out_ready` is 0, the word stays valid and its timestamp and column are held.
- R8: In triggered mode (`mode_trig`=1), a trigger pulse sampled while `ts_now`=T requests timestamp (T - `trig_lat`) mod 2^`TS_W`. Its first word is valid in the next cycle.
- R9: In triggered mode, hits are never emitted without a trigger. A pixel whose age (`ts_now` minus its stamp, modulo 2^`TS_W`) exceeds `trig_lat` is discarded.
- R10: A pixel whose word has been accepted is cleared and is not reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_trig | input | 1 | 0 = data push, 1 = triggered; changed only during reset |
| trig_lat | input | TS_W | Trigger latency in timestamp units |
| trig_in | input | 1 | Trigger pulse |
| hit_in | input | N_COLS*N_ROWS | Pixel hit pulses, index c*N_ROWS + r |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Word available |
| out_ts | output | TS_W | Timestamp of the word |
| out_col | output | COL_W | Column index of the word |
| out_rows | output | N_ROWS | Row-hit bitmap of the column |
| ts_now | output | TS_W | Broadcast timestamp |

## Verification
Hits are stored at the clock edge after the pulse, and the word path from the stored stamps to the port has no register. A data-push word is therefore due in the first cycle in which `ts_now` shows the next value. A triggered word is due one cycle after the trigger is sampled. Each further column follows one accepted cycle later. The bench drives and samples on falling edges and waits for the exact `ts_now` transition before it acts. This leaves seven clocks of a stable timestamp, so each expected word is checked in the precise cycle it is due, and the cycle after the last column is checked for silence. Discard and ignore behaviour is observed at the ports, as words that are missing or narrower than they would otherwise be.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    RD_PUSH = 1'b0,
    RD_TRIG = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/tsr_tick.sv
module tsr_tick #(
  parameter int TS_W     = 4,
  parameter int TICK_DIV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q, div_n;
  logic [TS_W-1:0]  ts_q, ts_n;
  logic             wrap;

  always_comb begin
    wrap = (div_q == DIV_W'(TICK_DIV - 1));
    div_n = wrap ? '0 : div_q + 1'b1;
    ts_n  = wrap ? ts_q + 1'b1 : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= div_n;
      ts_q  <= ts_n;
    end
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/tsr_column.sv
module tsr_column #(
  parameter int N_ROWS = 8,
  parameter int TS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ROWS-1:0] hit_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [TS_W-1:0]   req_ts_i,
  input  logic              expire_en_i,
  input  logic              protect_i,
  input  logic [TS_W-1:0]   lat_i,
  input  logic              rd_clr_i,
  output logic [N_ROWS-1:0] match_o,
  output logic              any_o
);
  logic [N_ROWS-1:0] occ_q, occ_n, cap;
  logic [TS_W-1:0]   stamp_q [N_ROWS];

  always_comb begin
    logic [TS_W-1:0] age;
    for (int r = 0; r < N_ROWS; r++) begin
      match_o[r] = occ_q[r] && (stamp_q[r] == req_ts_i);
      age        = ts_i - stamp_q[r];
      cap[r]     = 1'b0;
      occ_n[r]   = occ_q[r];
      if (occ_q[r]) begin
        if ((rd_clr_i && match_o[r]) ||
            (expire_en_i && (age > lat_i) && !(protect_i && match_o[r])))
          occ_n[r] = 1'b0;
      end else if (hit_i[r]) begin
        occ_n[r] = 1'b1;
        cap[r]   = 1'b1;
      end
    end
    any_o = |match_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int r = 0; r < N_ROWS; r++) stamp_q[r] <= '0;
    end else begin
      occ_q <= occ_n;
      for (int r = 0; r < N_ROWS; r++)
        if (cap[r]) stamp_q[r] <= ts_i;
    end
  end
endmodule

// File: rtl/tsr_pick.sv
module tsr_pick #(
  parameter int N_COLS = 8,
  parameter int COL_W  = 3
) (
  input  logic [N_COLS-1:0] flags_i,
  output logic              any_o,
  output logic [COL_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_COLS - 1; i >= 0; i--)
      if (flags_i[i]) idx_o = COL_W'(i);
    any_o = |flags_i;
  end
endmodule

// File: rtl/tsr_readout.sv
module tsr_readout #(
  parameter int N_COLS   = 8,
  parameter int N_ROWS   = 8,
  parameter int TS_W     = 4,
  parameter int TICK_DIV = 8,
  localparam int COL_W   = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int N_PIX   = N_COLS * N_ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_trig,
  input  logic [TS_W-1:0]   trig_lat,
  input  logic              trig_in,
  input  logic [N_PIX-1:0]  hit_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [TS_W-1:0]   out_ts,
  output logic [COL_W-1:0]  out_col,
  output logic [N_ROWS-1:0] out_rows,
  output logic [TS_W-1:0]   ts_now
);
  import tsr_pkg::*;

  rd_mode_e          mode;
  logic [TS_W-1:0]   ts;
  logic [TS_W-1:0]   rd_ts_q, rd_ts_n;
  logic [TS_W-1:0]   trig_ts_q, trig_ts_n;
  logic              pend_q, pend_n;
  logic              active, accept, any_col;
  logic [TS_W-1:0]   req_ts;
  logic [N_COLS-1:0] col_flag;
  logic [N_ROWS-1:0] col_match [N_COLS];
  logic [COL_W-1:0]  sel;

  assign mode = rd_mode_e'(mode_trig);

  tsr_tick #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .ts_o(ts)
  );

  always_comb begin
    active = (mode == RD_TRIG) ? pend_q : (rd_ts_q != ts);
    req_ts = (mode == RD_TRIG) ? trig_ts_q : rd_ts_q;
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    tsr_column #(.N_ROWS(N_ROWS), .TS_W(TS_W)) col_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit_in[c*N_ROWS +: N_ROWS]),
      .ts_i       (ts),
      .req_ts_i   (req_ts),
      .expire_en_i(mode == RD_TRIG),
      .protect_i  (pend_q),
      .lat_i      (trig_lat),
      .rd_clr_i   (accept && (sel == COL_W'(c))),
      .match_o    (col_match[c]),
      .any_o      (col_flag[c])
    );
  end

  tsr_pick #(.N_COLS(N_COLS), .COL_W(COL_W)) pick_i (
    .flags_i(col_flag), .any_o(any_col), .idx_o(sel)
  );

  always_comb begin
    out_valid = active && any_col;
    accept    = out_valid && out_ready;
    out_ts    = req_ts;
    out_col   = sel;
    out_rows  = col_match[sel];
    ts_now    = ts;
  end

  always_comb begin
    rd_ts_n   = rd_ts_q;
    pend_n    = pend_q;
    trig_ts_n = trig_ts_q;
    if (mode == RD_PUSH) begin
      if (active && !any_col) rd_ts_n = rd_ts_q + 1'b1;
    end else if (pend_q) begin
      if (!any_col) pend_n = 1'b0;
    end else if (trig_in) begin
      pend_n    = 1'b1;
      trig_ts_n = ts - trig_lat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ts_q   <= '0;
      trig_ts_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      rd_ts_q   <= rd_ts_n;
      trig_ts_q <= trig_ts_n;
      pend_q    <= pend_n;
    end
  end
endmodule

// File: rtl/tsr_readout_chk.sv
module tsr_readout_chk #(
  parameter int TS_W   = 4,
  parameter int COL_W  = 3,
  parameter int N_ROWS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TS_W-1:0]   out_ts,
  input logic [COL_W-1:0]  out_col,
  input logic [N_ROWS-1:0] out_rows,
  input logic [TS_W-1:0]   ts_now
);
  logic [TS_W-1:0] ts_prev_q, ts_prev_inc;
  logic            seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_prev_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      ts_prev_q <= ts_now;
      seen_q    <= 1'b1;
    end
  end
  assign ts_prev_inc = ts_prev_q + 1'b1;

  // R1
  first_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !out_valid);

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_now == ts_prev_q) || (ts_now == ts_prev_inc));

  // R5
  rows_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rows != '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_col)));
endmodule

bind tsr_readout tsr_readout_chk #(.TS_W(TS_W), .COL_W(COL_W), .N_ROWS(N_ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_ts(out_ts), .out_col(out_col), .out_rows(out_rows), .ts_now(ts_now)
);

// File: tb/tsr_readout_tb.sv
module tsr_readout_tb_top;
  localparam int NC = 8, NR = 8, TW = 4, DIV = 8;

  logic          clk, rst_n, mode_trig, trig_in, out_ready, out_valid;
  logic [TW-1:0] trig_lat, out_ts, ts_now;
  logic [NC*NR-1:0] hit_in;
  logic [2:0]    out_col;
  logic [NR-1:0] out_rows;
  int nchk = 0, nbad = 0;
  bit done = 0;

  tsr_readout #(.N_COLS(NC), .N_ROWS(NR), .TS_W(TW), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_trig(mode_trig), .trig_lat(trig_lat),
    .trig_in(trig_in), .hit_in(hit_in), .out_ready(out_ready),
    .out_valid(out_valid), .out_ts(out_ts), .out_col(out_col),
    .out_rows(out_rows), .ts_now(ts_now)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic expect_word(string req, logic v, logic [TW-1:0] t, logic [2:0] c, logic [NR-1:0] r);
    nchk++;
    if (out_valid !== v || (v && (out_ts !== t || out_col !== c || out_rows !== r))) begin
      nbad++;
      $display("FAIL %s: got v=%0b ts=%0d col=%0d rows=%h, exp v=%0b ts=%0d col=%0d rows=%h",
               req, out_valid, out_ts, out_col, out_rows, v, t, c, r);
    end
  endtask

  task automatic do_reset(logic trig, logic [TW-1:0] lat, bit measure);
    int n;
    @(negedge clk);
    rst_n = 0; mode_trig = trig; trig_lat = lat; trig_in = 0; hit_in = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 0 || ts_now !== 0) begin
      nbad++; $display("FAIL R1: v=%0b ts=%0d exp v=0 ts=0", out_valid, ts_now);
    end
    rst_n = 1;
    if (measure) begin
      n = 0;
      do begin @(negedge clk); n++; end while (ts_now == 0 && n < 100);
      nchk++;
      if (n != DIV) begin nbad++; $display("FAIL R2: first step after %0d clocks exp %0d", n, DIV); end
    end
  endtask

  task automatic wait_ts(logic [TW-1:0] v);
    logic [TW-1:0] p;
    p = ts_now;
    @(negedge clk);
    while (!(ts_now == v && p != v)) begin p = ts_now; @(negedge clk); end
  endtask

  task automatic pulse_hits(logic [NC*NR-1:0] h);
    hit_in = h;
    @(negedge clk);
    hit_in = '0;
  endtask

  task automatic pulse_trig;
    trig_in = 1;
    @(negedge clk);
    trig_in = 0;
  endtask

  function automatic logic [NC*NR-1:0] px(int c, int r);
    logic [NC*NR-1:0] m;
    m = '0; m[c*NR + r] = 1'b1;
    return m;
  endfunction

  // push-mode readout: R3 R5 R6 R10, stall R7, wrap R2
  task automatic t_push;
    do_reset(0, 0, 1);
    wait_ts(2);
    pulse_hits(px(1,3) | px(1,5) | px(4,0));
    wait_ts(3);
    expect_word("R6", 1, 2, 1, 8'h28);
    @(negedge clk); expect_word("R5", 1, 2, 4, 8'h01);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
    wait_ts(6);
    pulse_hits(px(0,2) | px(2,2) | px(2,3) | px(7,7));
    out_ready = 0;
    wait_ts(7);
    expect_word("R3", 1, 6, 0, 8'h04);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); expect_word("R7", 1, 6, 0, 8'h04);
    end
    out_ready = 1;
    @(negedge clk); expect_word("R5", 1, 6, 2, 8'h0C);
    @(negedge clk); expect_word("R5", 1, 6, 7, 8'h80);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
    wait_ts(15);
    pulse_hits(px(6,7));
    wait_ts(0);
    expect_word("R2", 1, 15, 6, 8'h80);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
  endtask

  // triggered selection and expiry: R8 R9
  task automatic t_trig_sel;
    do_reset(1, 2, 0);
    wait_ts(3);
    pulse_hits(px(2,1));
    wait_ts(4);
    expect_word("R9", 0, 0, 0, 0);
    pulse_hits(px(5,6));
    wait_ts(5);
    pulse_trig();
    expect_word("R8", 1, 3, 2, 8'h02);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
    wait_ts(8);
    trig_lat = 4;
    pulse_trig();
    expect_word("R9", 0, 0, 0, 0);
    @(negedge clk); expect_word("R9", 0, 0, 0, 0);
  endtask

  // busy pixel ignores hits: R4
  task automatic t_busy;
    do_reset(1, 3, 0);
    wait_ts(1);
    pulse_hits(px(0,0));
    wait_ts(2);
    pulse_hits(px(0,0) | px(0,4));
    wait_ts(4);
    pulse_trig();
    expect_word("R4", 1, 1, 0, 8'h01);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
    wait_ts(5);
    pulse_trig();
    expect_word("R4", 1, 2, 0, 8'h10);
  endtask

  // modular latency subtraction: R8 R2
  task automatic t_wrap_trig;
    do_reset(1, 3, 0);
    wait_ts(14);
    pulse_hits(px(3,2));
    wait_ts(1);
    pulse_trig();
    expect_word("R8", 1, 14, 3, 8'h04);
    @(negedge clk); expect_word("R10", 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; mode_trig = 0; trig_lat = 0; trig_in = 0; hit_in = '0; out_ready = 1;
    t_push();
    t_trig_sel();
    t_busy();
    t_wrap_trig();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule